// File: doc/BRIEF.md
# Temperature-Indexed Trim Code Loader

This block keeps the two trim codes of a series-resistor voltage reference in step with die temperature. It watches a 16-bit thermometer code from an on-chip temperature sensor, turns a well-formed pattern into one of fourteen calibration-point indices, and fetches the matching correction byte from an external serial EEPROM with an I2C random read. The byte is split into two 4-bit codes, A and S. Each code is held in a register and decoded to a 16-wide one-hot switch-select vector for the resistor trim array.

The sensor code is a plain level input with no handshake. The block samples it every cycle and acts only on the index it implies. The I2C pins are open-drain: `scl_low` and `sda_low` pull a line low when high, and `sda_in` reads the resolved data line. A fetch runs only when the matched index differs from the index whose codes are currently loaded. The codes change together, and only after a complete read. A transfer that is not acknowledged leaves the old codes in place, raises `err`, and is retried.

Points 0 to 12 cover -40 °C to 80 °C in 10 °C steps. Point 13 is 85 °C. Point 6 (20 °C) and point 7 (30 °C) are programmed with identical bytes, so the room-temperature setting is the same whichever of the two matches.

Top module: `trim_fetch`

## Requirements
- R1: After reset, `code_a` and `code_s` are both 8, `sel_a` and `sel_s` are 16'h0100, `busy` and `err` are 0, and neither I2C line is pulled low.
- R2: A valid thermometer pattern (ones filled contiguously from bit 0, all-zero included) maps to index = number of ones, clamped to 13. The EEPROM word address read for it is BASE_ADDR + index (default BASE_ADDR 8'h10).
- R3: A pattern that is not a valid thermometer code is ignored: no I2C traffic starts and the codes do not change.
- R4: No fetch is started when the matched index equals the index whose codes are loaded.
- R5: A fetch is one I2C random read. It sends START, {DEV_ADDR,0} (default 7'h50), the word address, repeated START, {DEV_ADDR,1}, reads one data byte, sends a NACK, then STOP. SDA does not change while SCL is high inside a byte.
- R6: The read byte's high nibble becomes `code_a` and its low nibble becomes `code_s`, both in the same cycle. Neither changes before the data byte has been fully received.
- R7: When an address byte is not acknowledged, the block sends STOP, keeps the previous codes and sets `err`. `err` clears on the next successful read.
- R8: `busy` is high from the START of a fetch to its STOP. While `busy` is low, neither line is pulled low.
- R9: `sel_a` and `sel_s` are one-hot, with bit `code_a` and bit `code_s` set respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_code | input | 16 | Thermometer code from the temperature sensor |
| sda_in | input | 1 | Resolved I2C data line |
| scl_low | output | 1 | Pull I2C clock low when 1 |
| sda_low | output | 1 | Pull I2C data low when 1 |
| code_a | output | 4 | Loaded A trim code |
| code_s | output | 4 | Loaded S trim code |
| sel_a | output | 16 | One-hot switch select for A |
| sel_s | output | 16 | One-hot switch select for S |
| busy | output | 1 | I2C transaction in progress |
| err | output | 1 | Last fetch attempt was not acknowledged |

## Verification
A wrong loaded-index register would show up at the pins within a few cycles of a temperature step. The block would either start a read it should skip, or stay idle, so the bench counts START conditions on the bus after every stimulus. A corrupted address or shift register would show up in the byte the EEPROM model captures in that same transaction. A mis-timed code update would be seen when the codes are sampled at the repeated START, before the data byte arrives. An error-path fault would be seen at the first STOP after an unacknowledged device byte.

// File: rtl/trim_pkg.sv
package trim_pkg;
  // Segments of the random-read transaction, in bus order.
  typedef enum logic [2:0] {
    SG_IDLE, SG_START1, SG_DEVW, SG_ADDR, SG_START2, SG_DEVR, SG_DATA, SG_STOP
  } seg_e;
endpackage

// File: rtl/trim_thermo_idx.sv
module trim_thermo_idx #(
  parameter int TEMP_W = 16,
  parameter int NPOINT = 14,
  localparam int IDX_W = $clog2(NPOINT)
) (
  input  logic [TEMP_W-1:0] therm,
  output logic              valid,
  output logic [IDX_W-1:0]  idx
);
  localparam int CNT_W = $clog2(TEMP_W + 1);
  logic [CNT_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < TEMP_W; i++) ones = ones + CNT_W'(therm[i]);
    // contiguous fill from bit 0: adding one clears every set bit
    valid = ((therm & (therm + TEMP_W'(1))) == '0);
    if (ones > CNT_W'(NPOINT - 1)) idx = IDX_W'(NPOINT - 1);
    else                           idx = ones[IDX_W-1:0];
  end
endmodule

// File: rtl/trim_onehot_dec.sv
module trim_onehot_dec #(
  parameter int CODE_W = 4,
  localparam int SEL_W = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code,
  output logic [SEL_W-1:0]  sel
);
  for (genvar i = 0; i < SEL_W; i++) begin : g_bit
    assign sel[i] = (code == CODE_W'(i));
  end
endmodule

// File: rtl/trim_i2c_rd.sv
module trim_i2c_rd #(
  parameter int         DIV      = 4,
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] word_addr,
  input  logic       sda_in,
  output logic       busy,
  output logic       done,
  output logic       ok,
  output logic [7:0] rd_byte,
  output logic       scl_low,
  output logic       sda_low
);
  import trim_pkg::*;
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

  seg_e             seg;
  logic [1:0]       q;
  logic [3:0]       bitn;
  logic [7:0]       shreg, rx, waddr;
  logic             nak, fail, tick, is_byte, tx_bit;
  logic [DIV_W-1:0] dcnt;

  assign tick    = (dcnt == '0);
  assign busy    = (seg != SG_IDLE);
  assign is_byte = (seg == SG_DEVW) || (seg == SG_ADDR) || (seg == SG_DEVR) || (seg == SG_DATA);
  // released (1) for ack slots, data bits and the closing NACK
  assign tx_bit  = (seg == SG_DATA) || (bitn == 4'd8) || shreg[7];

  always_ff @(posedge clk) begin
    if (!rst_n) dcnt <= '0;
    else if (tick) dcnt <= DIV_W'(DIV - 1);
    else dcnt <= dcnt - DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg <= SG_IDLE; q <= '0; bitn <= '0; shreg <= '0; rx <= '0; waddr <= '0;
      nak <= 1'b0; fail <= 1'b0; done <= 1'b0; ok <= 1'b0; rd_byte <= '0;
      scl_low <= 1'b0; sda_low <= 1'b0;
    end else begin
      done <= 1'b0;
      if (seg == SG_IDLE) begin
        if (start) begin
          seg <= SG_START1; q <= '0; waddr <= word_addr; fail <= 1'b0;
        end
      end else if (tick) begin
        q <= q + 2'd1;
        case (seg)
          SG_START1, SG_START2: begin
            case (q)
              2'd0: sda_low <= 1'b0;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b1;
              default: begin
                scl_low <= 1'b1;
                bitn    <= '0;
                seg     <= (seg == SG_START1) ? SG_DEVW : SG_DEVR;
                shreg   <= (seg == SG_START1) ? {DEV_ADDR, 1'b0} : {DEV_ADDR, 1'b1};
              end
            endcase
          end
          SG_STOP: begin
            case (q)
              2'd0: sda_low <= 1'b1;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b0;
              default: begin
                seg  <= SG_IDLE;
                done <= 1'b1;
                ok   <= ~fail;
                if (!fail) rd_byte <= rx;
              end
            endcase
          end
          default: begin
            case (q)
              2'd0: sda_low <= ~tx_bit;
              2'd1: scl_low <= 1'b0;
              2'd2: begin
                if (seg == SG_DATA && bitn != 4'd8) rx <= {rx[6:0], sda_in};
                if (bitn == 4'd8) nak <= sda_in;
              end
              default: begin
                scl_low <= 1'b1;
                if (bitn == 4'd8) begin
                  bitn <= '0;
                  if (seg != SG_DATA && nak) begin
                    fail <= 1'b1;
                    seg  <= SG_STOP;
                  end else begin
                    case (seg)
                      SG_DEVW: begin seg <= SG_ADDR; shreg <= waddr; end
                      SG_ADDR: seg <= SG_START2;
                      SG_DEVR: seg <= SG_DATA;
                      default: seg <= SG_STOP;
                    endcase
                  end
                end else begin
                  bitn  <= bitn + 4'd1;
                  shreg <= {shreg[6:0], 1'b0};
                end
              end
            endcase
          end
        endcase
      end
    end
  end

  // R8: an idle master leaves both lines released
  p_idle_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_low && !sda_low));
  // R5: within a byte, data only moves while the clock is low
  p_sda_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_byte && !scl_low && $past(!scl_low)) |-> $stable(sda_low));
endmodule

// File: rtl/trim_fetch.sv
module trim_fetch #(
  parameter int         TEMP_W     = 16,
  parameter int         NPOINT     = 14,
  parameter int         CODE_W     = 4,
  parameter int         DIV        = 4,
  parameter logic [6:0] DEV_ADDR   = 7'h50,
  parameter logic [7:0] BASE_ADDR  = 8'h10,
  parameter int         RESET_CODE = 8,
  localparam int        SEL_W      = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              sda_in,
  output logic              scl_low,
  output logic              sda_low,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_s,
  output logic [SEL_W-1:0]  sel_a,
  output logic [SEL_W-1:0]  sel_s,
  output logic              busy,
  output logic              err
);
  localparam int IDX_W = $clog2(NPOINT);

  logic             t_valid, cur_vld, loaded_vld;
  logic [IDX_W-1:0] t_idx, cur_idx, loaded_idx, fetch_idx;
  logic             m_start, m_done, m_ok;
  logic [7:0]       m_byte, word_addr;

  trim_thermo_idx #(.TEMP_W(TEMP_W), .NPOINT(NPOINT)) u_idx (
    .therm(temp_code), .valid(t_valid), .idx(t_idx));

  assign m_start   = cur_vld && !(loaded_vld && cur_idx == loaded_idx) && !busy && !m_done;
  assign word_addr = BASE_ADDR + 8'(cur_idx);

  trim_i2c_rd #(.DIV(DIV), .DEV_ADDR(DEV_ADDR)) u_bus (
    .clk(clk), .rst_n(rst_n), .start(m_start), .word_addr(word_addr), .sda_in(sda_in),
    .busy(busy), .done(m_done), .ok(m_ok), .rd_byte(m_byte),
    .scl_low(scl_low), .sda_low(sda_low));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_vld <= 1'b0; cur_idx <= '0; loaded_vld <= 1'b0; loaded_idx <= '0; fetch_idx <= '0;
      code_a <= CODE_W'(RESET_CODE); code_s <= CODE_W'(RESET_CODE); err <= 1'b0;
    end else begin
      if (t_valid) begin
        cur_vld <= 1'b1;
        cur_idx <= t_idx;
      end
      if (m_start) fetch_idx <= cur_idx;
      if (m_done) begin
        if (m_ok) begin
          code_a     <= m_byte[2*CODE_W-1:CODE_W];
          code_s     <= m_byte[CODE_W-1:0];
          loaded_idx <= fetch_idx;
          loaded_vld <= 1'b1;
          err        <= 1'b0;
        end else begin
          err <= 1'b1;
        end
      end
    end
  end

  trim_onehot_dec #(.CODE_W(CODE_W)) u_dec_a (.code(code_a), .sel(sel_a));
  trim_onehot_dec #(.CODE_W(CODE_W)) u_dec_s (.code(code_s), .sel(sel_s));

  // R6: codes move only on a completed, acknowledged read
  p_codes_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_done && m_ok) |=> ($stable(code_a) && $stable(code_s)));
  // R7: a failed transfer raises the error flag
  p_err_on_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_done && !m_ok) |=> err);
  // R9: decoder outputs one-hot at the code position
  p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_a[code_a] && sel_s[code_s] && $countones(sel_a) == 1 && $countones(sel_s) == 1);
endmodule

// File: tb/trim_fetch_test.sv
module trim_fetch_test;
  localparam logic [7:0] BASE = 8'h10;
  localparam logic [6:0] DEV  = 7'h50;
  localparam int WD = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] temp = 16'h00F0;
  logic scl_low_m, sda_low_m, slv_low = 1'b0, scl_l, sda_l;
  logic [3:0] code_a, code_s;
  logic [15:0] sel_a, sel_s;
  logic busy, err;
  assign scl_l = ~scl_low_m;
  assign sda_l = ~(sda_low_m | slv_low);

  trim_fetch uut (
    .clk(clk), .rst_n(rst_n), .temp_code(temp), .sda_in(sda_l),
    .scl_low(scl_low_m), .sda_low(sda_low_m), .code_a(code_a), .code_s(code_s),
    .sel_a(sel_a), .sel_s(sel_s), .busy(busy), .err(err));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  always @(posedge clk) cycles <= cycles + 1;

  // ---------------- EEPROM model ----------------
  logic [7:0] mem [256];
  logic ack_en = 1'b1, active = 1'b0, reading = 1'b0, acked = 1'b0, rd_mode = 1'b0, nack_seen = 1'b0;
  logic [7:0] sh = '0, outb = '0, waddr = '0, seen_devw = '0, seen_addr = '0, seen_devr = '0;
  int bitc = 0, byte_no = 0, start_cnt = 0, stop_cnt = 0;

  function automatic logic [7:0] exp_byte(int i);
    int k = (i == 7) ? 6 : i;  // 20 C and 30 C share one setting
    return {4'(k + 3), 4'(12 - k)};
  endfunction

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 8'hA5;
    for (int i = 0; i < 14; i++) mem[BASE + 8'(i)] = exp_byte(i);
  end

  always @(negedge sda_l) if (scl_l === 1'b1) begin
    start_cnt++; active = 1'b1; bitc = 0; byte_no = 0; reading = 1'b0; slv_low = 1'b0;
  end
  always @(posedge sda_l) if (scl_l === 1'b1 && active) begin
    stop_cnt++; active = 1'b0; reading = 1'b0; slv_low = 1'b0;
  end
  always @(posedge scl_l) if (active) begin
    if (reading) begin
      if (bitc == 8) nack_seen = sda_l;
    end else if (bitc < 8) sh = {sh[6:0], sda_l};
    bitc++;
  end
  always @(negedge scl_l) if (active) begin
    if (!reading) begin
      if (bitc == 8) begin
        if (byte_no == 0) begin
          rd_mode = sh[0];
          acked = ack_en && (sh[7:1] == DEV);
          if (sh[0]) seen_devr = sh; else seen_devw = sh;
        end else begin
          if (byte_no == 1) begin waddr = sh; seen_addr = sh; end
          acked = ack_en;
        end
        byte_no++;
        slv_low = acked;
      end else if (bitc == 9) begin
        slv_low = 1'b0; bitc = 0;
        if (acked && rd_mode) begin
          reading = 1'b1; outb = mem[waddr]; slv_low = ~outb[7];
        end
      end
    end else begin
      if (bitc >= 1 && bitc <= 7) slv_low = ~outb[7 - bitc];
      else slv_low = 1'b0;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wait_busy(logic lvl, int lim, output logic hit);
    hit = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (busy === lvl) begin hit = 1'b1; break; end
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0; temp = 16'h00F0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (60) @(negedge clk);
    chk("R1", "code_a", 32'(code_a), 32'd8);
    chk("R1", "code_s", 32'(code_s), 32'd8);
    chk("R1", "sel_a", 32'(sel_a), 32'h0100);
    chk("R1", "sel_s", 32'(sel_s), 32'h0100);
    chk("R1", "busy/err", {busy, err}, 32'd0);
    chk("R1", "lines", {scl_low_m, sda_low_m}, 32'd0);
    chk("R3", "no START for invalid pattern", 32'(start_cnt), 32'd0);
  endtask

  task automatic t_fetch(logic [15:0] pat, int idx);
    logic hit;
    logic [3:0] pa = code_a, ps = code_s;
    int s0 = start_cnt, p0 = stop_cnt;
    logic [7:0] e = exp_byte(idx);
    temp = pat;
    wait_busy(1'b1, 50, hit);
    chk("R8", "busy rises", 32'(hit), 32'd1);
    for (int i = 0; i < 3000 && start_cnt < s0 + 2; i++) @(negedge clk);
    chk("R6", "code_a before data", 32'(code_a), 32'(pa));
    chk("R6", "code_s before data", 32'(code_s), 32'(ps));
    chk("R8", "busy mid-transfer", 32'(busy), 32'd1);
    wait_busy(1'b0, 4000, hit);
    repeat (3) @(negedge clk);
    chk("R2", "word address", 32'(seen_addr), 32'(BASE + 8'(idx)));
    chk("R5", "write device byte", 32'(seen_devw), 32'({DEV, 1'b0}));
    chk("R5", "read device byte", 32'(seen_devr), 32'({DEV, 1'b1}));
    chk("R5", "NACK on data", 32'(nack_seen), 32'd1);
    chk("R5", "START count", 32'(start_cnt - s0), 32'd2);
    chk("R5", "STOP count", 32'(stop_cnt - p0), 32'd1);
    chk("R6", "code_a high nibble", 32'(code_a), 32'(e[7:4]));
    chk("R6", "code_s low nibble", 32'(code_s), 32'(e[3:0]));
    chk("R9", "sel_a", 32'(sel_a), 32'(16'd1 << e[7:4]));
    chk("R9", "sel_s", 32'(sel_s), 32'(16'd1 << e[3:0]));
    chk("R7", "err clear", 32'(err), 32'd0);
  endtask

  task automatic t_nofetch(logic [15:0] pat, string req);
    logic [3:0] pa = code_a, ps = code_s;
    int s0 = start_cnt;
    temp = pat;
    repeat (800) @(negedge clk);
    chk(req, "no START", 32'(start_cnt), 32'(s0));
    chk(req, "busy low", 32'(busy), 32'd0);
    chk(req, "codes unchanged", {code_a, code_s}, {pa, ps});
  endtask

  task automatic t_nack();
    logic [3:0] pa = code_a, ps = code_s;
    logic [7:0] e = exp_byte(5);
    int p0 = stop_cnt;
    ack_en = 1'b0;
    temp = 16'h001F;
    for (int i = 0; i < 4000 && err !== 1'b1; i++) @(negedge clk);
    chk("R7", "err set", 32'(err), 32'd1);
    chk("R7", "codes kept", {code_a, code_s}, {pa, ps});
    chk("R7", "STOP after abort", 32'(stop_cnt > p0), 32'd1);
    ack_en = 1'b1;
    for (int i = 0; i < 8000 && !(err === 1'b0 && busy === 1'b0); i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R7", "err cleared", 32'(err), 32'd0);
    chk("R7", "codes after retry", {code_a, code_s}, {e[7:4], e[3:0]});
  endtask

  initial begin
    wait (cycles >= WD);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    summary();
  end

  initial begin
    t_reset();
    t_fetch(16'h0000, 0);         // R2 all-zero is point 0
    t_nofetch(16'h0000, "R4");    // same point again
    t_nofetch(16'h00F0, "R3");    // gap below the ones
    t_fetch(16'h003F, 6);
    t_fetch(16'h007F, 7);         // R4 new index fetches even with equal codes
    t_fetch(16'h1FFF, 13);
    t_nofetch(16'hFFFF, "R2");    // clamps to the loaded point
    t_fetch(16'h0007, 3);
    t_fetch(16'hFFFF, 13);        // R2 clamp drives address of point 13
    t_nack();
    summary();
  end
endmodule